// File: doc/BRIEF.md
# Adaptive Transmit FIFO Trigger Level

This block holds the threshold that sets how much data must sit in the transmit FIFO before it is released to the medium. The threshold is 6 bits wide, and each unit stands for 64 bytes. Software or an underrun monitor makes it larger or smaller with single-cycle request pulses. A larger threshold costs latency on short frames. A smaller one makes underruns more likely. An increase moves the level halfway toward the ceiling, and a decrease lowers it by one unit, so the level climbs fast after an underrun and comes down slowly.

Each update runs as a short fixed sequence. First the global interrupt enable that the block passes on to the interrupt fabric is forced low. Then the new level and the limit verdict are written. Finally the enable goes back to the value it had when the request was accepted, and a one-cycle completion pulse is raised. A request that would leave the level where it is counts as a limit error: a decrease from the floor, or an increase whose half-gap rounds down to zero. Such a request still runs the full masking sequence.

Top module: `tx_trig_level`

## Requirements
- R1: After reset the level is TH_MIN (default 1, meaning 64 bytes), with done_o, limit_err_o and irq_en_o all low.
- R2: A decrease accepted at a level above TH_MIN lowers the level by exactly one and clears limit_err_o.
- R3: A decrease accepted at level TH_MIN leaves the level unchanged and sets limit_err_o.
- R4: An increase accepted at level L, where TH_MAX - L is 2 or more, sets the level to L + floor((TH_MAX - L) / 2) and clears limit_err_o.
- R5: An increase accepted when TH_MAX - L is below 2 leaves the level unchanged and sets limit_err_o.
- R6: When inc_req_i and dec_req_i are both high at the accepting edge, the update is an increase.
- R7: irq_en_o is low from the cycle after acceptance until the completion cycle. In the completion cycle it equals the value irq_en_i had at the accepting edge, on both the success path and the error path.
- R8: A request is accepted at an edge where the block is idle. The new level and limit_err_o are visible one cycle after acceptance. done_o is high for exactly one cycle, two cycles after acceptance.
- R9: Requests that arrive while an update is in progress have no effect on the level or on the error flag.
- R10: The level always stays within TH_MIN..TH_MAX and changes only in the apply cycle of an accepted update.
- R11: While the block is idle, irq_en_o follows irq_en_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_req_i | input | 1 | Request to raise the threshold |
| dec_req_i | input | 1 | Request to lower the threshold |
| irq_en_i | input | 1 | Global interrupt enable requested upstream |
| level_o | output | TH_W | Current threshold, in units of 64 bytes |
| done_o | output | 1 | One-cycle pulse that marks the end of an update |
| limit_err_o | output | 1 | Outcome of the latest update: 1 if it hit a limit and changed nothing |
| irq_en_o | output | 1 | Global interrupt enable, masked while an update is applied |

## Verification
The assertions assume that the request inputs and irq_en_i are clean synchronous levels, and that TH_MIN < TH_MAX fits in TH_W bits. The restore check also assumes that each acceptance lies at least three cycles after reset release. The stimulus drives every input on the falling edge. Requests are single-cycle pulses that the bench issues only after the previous completion, except when it tests rejection while busy. irq_en_i is randomised per update and is changed in the middle of one update on purpose, to confirm that the restored value is the one captured at acceptance.

// File: rtl/txtl_pkg.sv
package txtl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_APPLY  = 2'd1,
    ST_FINISH = 2'd2
  } txtl_state_e;
endpackage

// File: rtl/txtl_calc.sv
module txtl_calc #(
  parameter int TH_W   = 6,
  parameter int TH_MIN = 1,
  parameter int TH_MAX = 63
) (
  input  logic [TH_W-1:0] cur_i,
  input  logic            op_inc_i,
  output logic [TH_W-1:0] nxt_o,
  output logic            err_o
);
  localparam logic [TH_W-1:0] MIN_L = TH_W'(TH_MIN);
  localparam logic [TH_W-1:0] MAX_L = TH_W'(TH_MAX);

  logic [TH_W-1:0] gap;
  logic [TH_W-1:0] half;

  always_comb begin
    gap  = MAX_L - cur_i;
    half = gap >> 1;
    if (op_inc_i) begin
      err_o = (half == '0);
      nxt_o = err_o ? cur_i : cur_i + half;
    end else begin
      err_o = (cur_i <= MIN_L);
      nxt_o = err_o ? cur_i : cur_i - 1'b1;
    end
  end
endmodule

// File: rtl/txtl_ctrl.sv
module txtl_ctrl
  import txtl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc_req_i,
  input  logic dec_req_i,
  input  logic irq_en_i,
  output logic load_o,
  output logic op_inc_o,
  output logic irq_en_o,
  output logic done_o
);
  txtl_state_e state;
  logic        saved_en;
  logic        irq_q;
  logic        done_q;
  logic        op_q;
  logic        accept;

  assign accept = (state == ST_IDLE) && (inc_req_i || dec_req_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      saved_en <= 1'b0;
      irq_q    <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          irq_q <= irq_en_i;
          if (accept) begin
            state    <= ST_APPLY;
            op_q     <= inc_req_i;
            saved_en <= irq_en_i;
            irq_q    <= 1'b0;
          end
        end
        ST_APPLY: state <= ST_FINISH;
        ST_FINISH: begin
          irq_q  <= saved_en;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = (state == ST_APPLY);
  assign op_inc_o = op_q;
  assign irq_en_o = irq_q;
  assign done_o   = done_q;

  // R7: masking takes effect right after acceptance
  a_r7_mask_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_en_o);
  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: apply cycle follows acceptance
  a_r8_apply_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> load_o);
endmodule

// File: rtl/txtl_level_reg.sv
module txtl_level_reg #(
  parameter int TH_W   = 6,
  parameter int TH_MIN = 1,
  parameter int TH_MAX = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [TH_W-1:0] nxt_i,
  input  logic            err_i,
  output logic [TH_W-1:0] level_o,
  output logic            err_o
);
  localparam logic [TH_W-1:0] MIN_L = TH_W'(TH_MIN);
  localparam logic [TH_W-1:0] MAX_L = TH_W'(TH_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o <= MIN_L;
      err_o   <= 1'b0;
    end else if (load_i) begin
      level_o <= nxt_i;
      err_o   <= err_i;
    end
  end

  // R10: level stays in range
  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o >= MIN_L) && (level_o <= MAX_L));
  // R10 / R9: level moves only in an apply cycle
  a_r10_change_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(level_o));
  // R3 / R5: a limit error leaves the level untouched
  a_r3_err_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && err_i) |=> $stable(level_o));
endmodule

// File: rtl/tx_trig_level.sv
module tx_trig_level #(
  parameter int TH_W   = 6,
  parameter int TH_MIN = 1,
  parameter int TH_MAX = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_req_i,
  input  logic            dec_req_i,
  input  logic            irq_en_i,
  output logic [TH_W-1:0] level_o,
  output logic            done_o,
  output logic            limit_err_o,
  output logic            irq_en_o
);
  logic            load;
  logic            op_inc;
  logic [TH_W-1:0] nxt;
  logic            calc_err;

  txtl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inc_req_i(inc_req_i), .dec_req_i(dec_req_i),
    .irq_en_i(irq_en_i), .load_o(load), .op_inc_o(op_inc),
    .irq_en_o(irq_en_o), .done_o(done_o)
  );

  txtl_calc #(.TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX)) u_calc (
    .cur_i(level_o), .op_inc_i(op_inc), .nxt_o(nxt), .err_o(calc_err)
  );

  txtl_level_reg #(.TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX)) u_reg (
    .clk(clk), .rst_n(rst_n), .load_i(load), .nxt_i(nxt), .err_i(calc_err),
    .level_o(level_o), .err_o(limit_err_o)
  );

  // R7: restored enable equals the value captured at acceptance
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (irq_en_o == $past(irq_en_i, 3)));
  // R7: enable is masked in the cycle before completion
  a_r7_masked_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !$past(irq_en_o));
endmodule

// File: tb/tx_trig_level_test.sv
module tx_trig_level_test;
  localparam int CLK_PERIOD = 10;
  localparam int TH_W = 6;
  localparam int TH_MIN = 1;
  localparam int TH_MAX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_req_i = 1'b0;
  logic dec_req_i = 1'b0;
  logic irq_en_i = 1'b0;
  logic [TH_W-1:0] level_o;
  logic done_o, limit_err_o, irq_en_o;

  int n_tests = 0;
  int n_fail = 0;
  int exp_level = TH_MIN;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_trig_level #(.TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .inc_req_i(inc_req_i), .dec_req_i(dec_req_i),
    .irq_en_i(irq_en_i), .level_o(level_o), .done_o(done_o),
    .limit_err_o(limit_err_o), .irq_en_o(irq_en_o)
  );

  function automatic int model_next(int cur, bit inc);
    if (inc) return ((TH_MAX - cur) / 2 == 0) ? cur : cur + (TH_MAX - cur) / 2;
    return (cur <= TH_MIN) ? cur : cur - 1;
  endfunction

  function automatic bit model_err(int cur, bit inc);
    if (inc) return ((TH_MAX - cur) / 2 == 0);
    return (cur <= TH_MIN);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One update; when busy_poke is set, a dec request is driven during apply (R9)
  task automatic do_update(bit inc, bit dec, bit irq, bit busy_poke, bit flip_irq, string req);
    bit eff_inc;
    int nlev;
    bit nerr;
    eff_inc = inc;  // R6: increase wins on a tie
    nlev = model_next(exp_level, eff_inc);
    nerr = model_err(exp_level, eff_inc);
    @(negedge clk);
    irq_en_i  = irq;
    @(negedge clk);
    inc_req_i = inc;
    dec_req_i = dec;
    @(negedge clk);                       // after accepting edge
    inc_req_i = 1'b0;
    dec_req_i = busy_poke;
    if (flip_irq) irq_en_i = ~irq;
    check({req, " R7 masked"}, irq_en_o, 0);
    @(negedge clk);                       // after apply edge
    dec_req_i = 1'b0;
    check({req, " level"}, level_o, nlev);
    check({req, " err"}, limit_err_o, nerr);
    check({req, " R8 no early done"}, done_o, 0);
    @(negedge clk);                       // completion cycle
    check({req, " R8 done"}, done_o, 1);
    check({req, " R7 restore"}, irq_en_o, irq);
    @(negedge clk);
    check({req, " R8 done pulse ends"}, done_o, 0);
    if (busy_poke) check({req, " R9 busy ignored"}, level_o, nlev);
    irq_en_i = irq;
    exp_level = nlev;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 level", level_o, TH_MIN);
    check("R1 done", done_o, 0);
    check("R1 err", limit_err_o, 0);
    check("R1 irq", irq_en_o, 0);
    rst_n = 1'b1;
    irq_en_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 follow high", irq_en_o, 1);
    irq_en_i = 1'b0;
    @(negedge clk);
    check("R11 follow low", irq_en_o, 0);

    do_update(0, 1, 1, 0, 0, "R3 floor dec");
    do_update(1, 0, 1, 0, 0, "R4 inc from min");
    check("R4 value 32", level_o, 32);
    for (int k = 0; k < 5; k++) do_update(1, 0, k[0], 0, 0, "R4 inc");
    check("R4 value 62", level_o, 62);
    do_update(1, 0, 1, 0, 0, "R5 gap one");
    check("R5 err", limit_err_o, 1);
    do_update(0, 1, 0, 0, 1, "R2 dec");
    check("R2 err clear", limit_err_o, 0);
    do_update(1, 1, 1, 0, 0, "R6 both");
    check("R6 inc won", level_o, 62);
    do_update(0, 1, 1, 1, 0, "R9 poke");
    do_update(0, 1, 0, 1, 1, "R9 poke flip");

    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      bit ri, rd;
      ri = $urandom_range(0, 1);
      rd = $urandom_range(0, 1);
      if (!ri && !rd) rd = 1'b1;
      do_update(ri, rd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), "R10 random");
      check("R10 range", int'(level_o >= TH_MIN && level_o <= TH_MAX), 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule